// File: doc/BRIEF.md
# Two-Wire Register Write Slave with Frame-Synchronous Commit

This block receives write transactions on a two-wire open-drain serial bus (I2C) and stores the data bytes in a bank of staging registers. The live control registers that the rest of the encoder reads do not change as each byte arrives. The host writes all the bytes it wants, then sets a commit flag. At the next falling edge of vertical sync, the whole staging bank is copied into the live bank at once. Control values therefore change only at a frame boundary, and never part-way through a picture.

A strap pin selects the device address. The write byte is 40h when the pin is low and 42h when it is high. In each transaction, the first data byte after the address byte is taken as the register index. Each byte after that goes to the next index. The commit flag is a single bit at its own index, and hardware clears it when a commit happens. The bus lines and the vertical sync input are brought into the system clock domain through flop chains, so the bus rate is set only by the ratio of the bus clock to the system clock.

Top module: `ctlreg_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte only when the byte equals 40h (pin `addrSel` low) or 42h (pin `addrSel` high). Any other address byte, including 41h and 43h, gets no acknowledge, and the rest of that transaction is ignored.
- R2: Transfers work at standard-mode timing (100 kHz, 2000 system clocks per bit at 200 MHz) and at fast-mode timing (400 kHz, 500 clocks per bit). They also work at any faster rate whose SCL high and low phases each last at least 8 system clocks.
- R3: Each acknowledged data byte is written to the staging register named by the current index. Staging register k appears, after a commit, at `liveRegs[8k+7:8k]`.
- R4: The first byte after a matching address byte sets the index. Each following data byte in the same transaction is written at the current index, and the index then increases by one.
- R5: Writes to staging have no effect on `liveRegs` until a commit occurs.
- R6: A commit copies all staging registers into `liveRegs`. A commit happens on the first falling edge of `vsyncIn` while the commit flag is set. A rising edge of `vsyncIn` never commits, and a falling edge while the flag is clear does nothing.
- R7: The commit flag is bit 0 of the byte written at index 1Fh. Writing 1 sets it and writing 0 clears it. Hardware clears the flag after each commit, so a later falling edge of `vsyncIn` with no new flag write leaves `liveRegs` unchanged.
- R8: A stop condition or a repeated start ends the transaction. After a repeated start and a matching address, the next byte is again taken as the index.
- R9: The slave pulls SDA low during the ninth clock of every acknowledged byte. It releases SDA within a few system clocks after SCL falls at the end of that clock, and it releases SDA on a stop.
- R10: Data bytes written at indices from the register count (8) up to 1Eh, and above 1Fh, change no staging register.
- R11: After reset, `liveRegs` is all zero, SDA is released and the commit flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock from the bus |
| sdaIn | input | 1 | Serial data as seen on the bus |
| addrSel | input | 1 | Address strap: 0 gives 40h, 1 gives 42h |
| vsyncIn | input | 1 | Vertical sync; its falling edge is the commit point |
| sdaPullDn | output | 1 | 1 pulls SDA low (acknowledge) |
| liveRegs | output | 64 | Live register bank, 8 bytes, register k in bits 8k+7:8k |

## Verification
Some internal faults show up at the next acknowledge slot on the bus. A wrong bit count or a wrong address compare makes the acknowledge appear on the wrong transactions, or not at all, in the ninth clock of the byte concerned. Other faults, such as a stale index, a missed auto-increment or a commit flag that fails to clear, cannot be seen until the next falling edge of `vsyncIn`. Then `liveRegs` holds a byte in the wrong lane, a value that should have stayed in staging, or no update at all. The bench therefore checks `liveRegs` both before and after every sync edge it drives.

// File: rtl/ctlreg_pkg.sv
`timescale 1ns/1ps
package ctlreg_pkg;
  localparam int BYTE_W = 8;

  // strobes handed from the bus controller to the register datapath
  typedef struct packed {
    logic              loadSub;  // received byte is a register index
    logic              wrData;   // received byte is data for the current index
    logic [BYTE_W-1:0] rxByte;
  } rxStrobe_t;
endpackage

// File: rtl/ctlreg_bus_ctrl.sv
`timescale 1ns/1ps
module ctlreg_bus_ctrl
  import ctlreg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_LO     = 7'h20,
  parameter logic [6:0] ADDR_HI     = 7'h21
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      addrSel,
  output logic      sdaPullDn,
  output rxStrobe_t strb
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_RX, PH_ACK} phase_t;
  typedef enum logic [1:0] {K_ADDR, K_SUB, K_DATA} kind_t;

  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic startDet, stopDet, sclRise, sclFall;
  phase_t phase;
  kind_t kind;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] shReg;
  logic sdaLow;
  logic [BYTE_W-1:0] myAddrByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh   <= '1;
      sdaSh   <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSh   <= {sclSh[SYNC_STAGES-2:0], sclIn};
      sdaSh   <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclSh[SYNC_STAGES-1];
  assign sdaS     = sdaSh[SYNC_STAGES-1];
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign myAddrByte = {(addrSel ? ADDR_HI : ADDR_LO), 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      kind   <= K_ADDR;
      bitCnt <= '0;
      shReg  <= '0;
      sdaLow <= 1'b0;
      strb   <= '0;
    end else begin
      strb.loadSub <= 1'b0;
      strb.wrData  <= 1'b0;
      if (startDet) begin
        phase  <= PH_RX;
        kind   <= K_ADDR;
        bitCnt <= '0;
        sdaLow <= 1'b0;
      end else if (stopDet) begin
        phase  <= PH_IDLE;
        kind   <= K_ADDR;
        sdaLow <= 1'b0;
      end else begin
        unique case (phase)
          PH_RX: begin
            if (sclRise && bitCnt < CNT_W'(BYTE_W)) begin
              shReg  <= {shReg[BYTE_W-2:0], sdaS};
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == CNT_W'(BYTE_W)) begin
              strb.rxByte <= shReg;
              unique case (kind)
                K_ADDR: begin
                  if (shReg == myAddrByte) begin
                    sdaLow <= 1'b1;
                    phase  <= PH_ACK;
                    kind   <= K_SUB;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                K_SUB: begin
                  strb.loadSub <= 1'b1;
                  sdaLow       <= 1'b1;
                  phase        <= PH_ACK;
                  kind         <= K_DATA;
                end
                default: begin
                  strb.wrData <= 1'b1;
                  sdaLow      <= 1'b1;
                  phase       <= PH_ACK;
                end
              endcase
            end
          end
          PH_ACK: begin
            if (sclFall) begin
              sdaLow <= 1'b0;
              phase  <= PH_RX;
              bitCnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaPullDn = sdaLow;

  // R9: a stop always leaves the bus released
  p_release_on_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaPullDn);
  // R9: acknowledge starts only while SCL is low
  p_ack_scl_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullDn) |-> !$past(sclS));
  // R4: a byte is either an index or data, never both
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadSub, strb.wrData}));
endmodule

// File: rtl/ctlreg_bank.sv
`timescale 1ns/1ps
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter int          NUM_REGS    = 8,
  parameter logic [7:0]  WE_SUB      = 8'h1F,
  parameter int          WE_BIT      = 0,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  rxStrobe_t                  strb,
  input  logic                       vsyncIn,
  output logic [NUM_REGS*BYTE_W-1:0] liveRegs
);
  logic [SYNC_STAGES-1:0] vsSh;
  logic vsS, vsPrev, vsFall;
  logic [BYTE_W-1:0] subPtr;
  logic weFlag, wrWe, commit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vsSh   <= '1;
      vsPrev <= 1'b1;
    end else begin
      vsSh   <= {vsSh[SYNC_STAGES-2:0], vsyncIn};
      vsPrev <= vsS;
    end
  end

  assign vsS    = vsSh[SYNC_STAGES-1];
  assign vsFall = vsPrev & ~vsS;
  assign commit = vsFall & weFlag;
  assign wrWe   = strb.wrData && (subPtr == WE_SUB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              subPtr <= '0;
    else if (strb.loadSub)  subPtr <= strb.rxByte;
    else if (strb.wrData)   subPtr <= subPtr + 1'b1;
  end

  // a flag write in the commit cycle wins so the host request is kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       weFlag <= 1'b0;
    else if (wrWe)   weFlag <= strb.rxByte[WE_BIT];
    else if (commit) weFlag <= 1'b0;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [BYTE_W-1:0] stageQ, liveQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        stageQ <= '0;
      else if (strb.wrData && subPtr == BYTE_W'(i))     stageQ <= strb.rxByte;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       liveQ <= '0;
      else if (commit) liveQ <= stageQ;
    end
    assign liveRegs[i*BYTE_W +: BYTE_W] = liveQ;
  end

  // R5: live bank only moves on a commit
  p_live_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> $stable(liveRegs));
  // R7: a commit consumes the flag unless rewritten in the same cycle
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (commit && !wrWe) |=> !weFlag);
  // R6: a rising sync edge never commits
  p_no_rise_commit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (vsS && !vsPrev) |-> !commit);
endmodule

// File: rtl/ctlreg_i2c_slave.sv
`timescale 1ns/1ps
module ctlreg_i2c_slave
  import ctlreg_pkg::*;
#(
  parameter int         NUM_REGS    = 8,
  parameter logic [7:0] WE_SUB      = 8'h1F,
  parameter int         WE_BIT      = 0,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_LO     = 7'h20,
  parameter logic [6:0] ADDR_HI     = 7'h21
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  input  logic                       addrSel,
  input  logic                       vsyncIn,
  output logic                       sdaPullDn,
  output logic [NUM_REGS*BYTE_W-1:0] liveRegs
);
  rxStrobe_t strb;

  ctlreg_bus_ctrl #(
    .SYNC_STAGES(SYNC_STAGES), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrSel(addrSel), .sdaPullDn(sdaPullDn), .strb(strb)
  );

  ctlreg_bank #(
    .NUM_REGS(NUM_REGS), .WE_SUB(WE_SUB), .WE_BIT(WE_BIT), .SYNC_STAGES(SYNC_STAGES)
  ) bank_i (
    .clk(clk), .rstN(rstN), .strb(strb), .vsyncIn(vsyncIn), .liveRegs(liveRegs)
  );
endmodule

// File: tb/ctlreg_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module ctlreg_i2c_slave_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic scl = 1'b1, masterSda = 1'b1, addrSel = 1'b0, vsync = 1'b1;
  logic sdaPullDn;
  logic [63:0] liveRegs;
  wire  sdaBus = masterSda & ~sdaPullDn;

  ctlreg_i2c_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus), .addrSel(addrSel),
    .vsyncIn(vsync), .sdaPullDn(sdaPullDn), .liveRegs(liveRegs)
  );

  int total = 0, bad = 0, q = 20;
  logic [63:0] expStage = '0, expLive = '0;
  logic expWe = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    masterSda = 1'b1; tick(q); scl = 1'b1; tick(q);
    masterSda = 1'b0; tick(q); scl = 1'b0; tick(q);
  endtask

  task automatic stopCond();
    masterSda = 1'b0; tick(q); scl = 1'b1; tick(q); masterSda = 1'b1; tick(q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackd, output logic rel);
    for (int i = 7; i >= 0; i--) begin
      masterSda = b[i]; tick(q); scl = 1'b1; tick(2*q); scl = 1'b0; tick(q);
    end
    masterSda = 1'b1; tick(q); scl = 1'b1; tick(q);
    ackd = ~sdaBus;
    tick(q); scl = 1'b0; tick(q);
    rel = sdaBus;
  endtask

  // one transaction: address, index, up to three data bytes (d[7:0] first)
  task automatic wrSeq(input logic sel, input logic [7:0] sub, input int n,
                       input logic [23:0] d, input string tag);
    logic a, r;
    logic [7:0] idx;
    addrSel = sel;
    startCond();
    sendByte(sel ? 8'h42 : 8'h40, a, r);
    chk(a === 1'b1, {tag, " R1 address ack"}, 64'(a), 64'd1);
    sendByte(sub, a, r);
    chk(a === 1'b1, {tag, " R4 index ack"}, 64'(a), 64'd1);
    idx = sub;
    for (int k = 0; k < n; k++) begin
      sendByte(d[k*8 +: 8], a, r);
      chk(a === 1'b1 && r === 1'b1, {tag, " R3 data ack and R9 release"}, {a, r}, 2'b11);
      if (idx < 8) expStage[idx*8 +: 8] = d[k*8 +: 8];
      if (idx == 8'h1F) expWe = d[k*8];
      idx++;
    end
    stopCond();
  endtask

  task automatic vsFallEdge();
    vsync = 1'b0; tick(12);
    if (expWe) begin expLive = expStage; expWe = 1'b0; end
    vsync = 1'b1; tick(12);
  endtask

  // vector table: sel, address byte, index, data, expected ack
  localparam int NV = 8;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 8'h40, 8'h00, 8'hA1, 1'b1},
    {1'b0, 8'h42, 8'h01, 8'hB2, 1'b0},
    {1'b1, 8'h42, 8'h02, 8'hC3, 1'b1},
    {1'b1, 8'h40, 8'h03, 8'hD4, 1'b0},
    {1'b0, 8'h41, 8'h04, 8'hE5, 1'b0},
    {1'b1, 8'h43, 8'h05, 8'hF6, 1'b0},
    {1'b0, 8'h40, 8'h09, 8'h77, 1'b1},
    {1'b1, 8'h42, 8'h07, 8'h18, 1'b1}
  };

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic a, r;
    logic [7:0] sub, dat;
    tick(5); rstN = 1'b1; tick(5);
    chk(liveRegs === 64'd0 && sdaPullDn === 1'b0, "R11 reset state", {sdaPullDn, liveRegs[62:0]}, 64'd0);

    for (int v = 0; v < NV; v++) begin
      addrSel = VEC[v][25];
      sub = VEC[v][16:9];
      dat = VEC[v][8:1];
      startCond();
      sendByte(VEC[v][24:17], a, r);
      chk(a === VEC[v][0], "R1 address match", 64'(a), 64'(VEC[v][0]));
      if (VEC[v][0]) begin
        sendByte(sub, a, r);
        sendByte(dat, a, r);
        chk(a === 1'b1 && r === 1'b1, "R9 data ack then release", {a, r}, 2'b11);
        if (sub < 8) expStage[sub*8 +: 8] = dat;
      end
      stopCond();
      chk(liveRegs === 64'd0, "R5 live unchanged before commit", liveRegs, 64'd0);
    end

    vsFallEdge();
    chk(liveRegs === 64'd0, "R6 no commit without flag", liveRegs, 64'd0);

    // flag set while sync low: the rising edge must not commit
    vsync = 1'b0; tick(12);
    wrSeq(1'b1, 8'h1F, 1, 24'h01, "flag");
    chk(liveRegs === 64'd0, "R5 flag set, waiting for edge", liveRegs, 64'd0);
    vsync = 1'b1; tick(12);
    chk(liveRegs === 64'd0, "R6 rising edge ignored", liveRegs, 64'd0);
    vsFallEdge();
    chk(liveRegs === expLive && expLive == 64'h1800_0000_00C3_00A1,
        "R6 R10 commit on falling edge", liveRegs, expLive);

    wrSeq(1'b0, 8'h00, 1, 24'h55, "rewrite");
    vsFallEdge();
    chk(liveRegs === expLive, "R7 flag cleared after commit", liveRegs, expLive);

    wrSeq(1'b0, 8'h02, 3, 24'h33_22_11, "autoinc");
    wrSeq(1'b0, 8'h1F, 1, 24'h01, "flag");
    vsFallEdge();
    chk(liveRegs === expLive && liveRegs[39:16] == 24'h332211, "R4 auto-increment", liveRegs, expLive);

    // repeated start: next byte after new address is an index again
    addrSel = 1'b0;
    startCond();
    sendByte(8'h40, a, r); sendByte(8'h00, a, r); sendByte(8'h99, a, r);
    expStage[7:0] = 8'h99;
    startCond();
    sendByte(8'h40, a, r);
    chk(a === 1'b1, "R8 address ack after repeated start", 64'(a), 64'd1);
    sendByte(8'h06, a, r); sendByte(8'h66, a, r);
    expStage[55:48] = 8'h66;
    stopCond();
    // stop: next transaction begins with an index
    wrSeq(1'b1, 8'h05, 1, 24'h5A, "stop1");
    wrSeq(1'b1, 8'h07, 1, 24'hAB, "stop2");
    wrSeq(1'b1, 8'h1F, 1, 24'h01, "flag");
    vsFallEdge();
    chk(liveRegs === expLive && liveRegs[63:40] == 24'hAB665A && liveRegs[7:0] == 8'h99,
        "R8 index reset by stop and repeated start", liveRegs, expLive);

    // flag write then clear: no commit
    wrSeq(1'b0, 8'h01, 1, 24'h3C, "pre");
    wrSeq(1'b0, 8'h1F, 1, 24'h01, "set");
    wrSeq(1'b0, 8'h1F, 1, 24'h00, "clr");
    vsFallEdge();
    chk(liveRegs === expLive && liveRegs[15:8] == 8'h00, "R7 flag written to zero", liveRegs, expLive);

    // standard-mode and fast-mode bit timing
    q = 500;
    wrSeq(1'b0, 8'h03, 1, 24'hC7, "std");
    q = 125;
    wrSeq(1'b1, 8'h1F, 1, 24'h01, "fast");
    q = 20;
    vsFallEdge();
    chk(liveRegs === expLive && liveRegs[31:24] == 8'hC7 && liveRegs[15:8] == 8'h3C,
        "R2 standard and fast mode", liveRegs, expLive);

    vsFallEdge();
    chk(liveRegs === expLive, "R7 second edge without flag", liveRegs, expLive);
    chk(sdaPullDn === 1'b0, "R9 bus released when idle", 64'(sdaPullDn), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule